// File: doc/BRIEF.md
# Core Test Wrapper

This block sits around a single embedded core and gives test equipment serial access to the core's boundary. Every input pin and every output pin of the core passes through a boundary cell. Each cell has a shift stage and an update stage. All cells are linked into one scan chain that runs from the wrapper serial input to the wrapper serial output. A one-bit bypass register and a 3-bit instruction register complete the set of serial paths.

The serial control lines act on the wrapper directly; there is no TAP state machine. The select-instruction line chooses between the instruction register and the data register that the current instruction names. Shift, capture and update pulses move data through whichever register is chosen. The decoded instruction also sets how the boundary cells treat the pins:
- pass-through for normal operation,
- driving the chip-side outputs for external test,
- driving the core inputs for internal test,
- holding the outputs still while the bypass bit carries the serial data (clamp).

Top module: `core_test_wrapper`

## Requirements
- R1: A synchronous active-high reset clears all shift, update and bypass stages and the serial output to 0. It loads instruction code 3'b000 (bypass), so the core pins pass through unchanged (core_in = pin_in, pin_out = core_out).
- R2: With sel_instr high and shift_en high, the instruction shift stage moves one place toward bit 0 on each rising wclk edge. wsi enters bit 2, and bit 0 is the bit presented at wso.
- R3: The active instruction changes only on a rising edge with update_en and sel_instr both high; it then takes the value of the instruction shift stage. An update pulse with sel_instr low leaves the instruction unchanged.
- R4: The bypass bit is the serial path for codes 3'b000, 3'b100 and the unused codes 3'b101 to 3'b111. In that case shift moves wsi into it, so wso shows each bit one cycle later, and a capture pulse clears it to 0.
- R5: For codes 3'b001 (external test), 3'b010 (preload) and 3'b011 (internal test), the boundary chain is the serial path. wsi enters input cell 0, data moves through the input cells in index order and then the output cells, and it leaves from the last output cell.
- R6: A capture pulse under external or internal test loads each input cell with its pin_in bit and each output cell with its core_out bit. Under preload, capture changes nothing.
- R7: The boundary update stages copy the shift stages on an update pulse with sel_instr low, but only while the boundary chain is selected. At all other times they hold.
- R8: Under preload the pins stay in pass-through while the chain is shifted and updated.
- R9: Under external test, pin_out is driven from the output cells' update stages and core_in follows pin_in.
- R10: Under internal test, core_in is driven from the input cells' update stages and pin_out follows core_out.
- R11: Under clamp (3'b100), pin_out is held at the output cells' update values, even when core_out moves and shift, capture or update pulses arrive.
- R12: wso is registered on the falling edge of wclk. It shows the bit that the rising edge before it left at the end of the selected path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Wrapper clock |
| wrst | input | 1 | Synchronous active-high reset |
| wsi | input | 1 | Wrapper serial input |
| shift_en | input | 1 | Shift the selected register |
| capture_en | input | 1 | Capture into the selected register |
| update_en | input | 1 | Copy shift stage to update stage |
| sel_instr | input | 1 | High selects the instruction register |
| pin_in | input | N_IN | Chip-side values headed for the core inputs |
| core_out | input | N_OUT | Values produced by the core |
| wso | output | 1 | Wrapper serial output, falling-edge registered |
| core_in | output | N_IN | Values applied to the core inputs |
| pin_out | output | N_OUT | Values sent from the core toward the chip |

## Verification
The bench builds the wrapper with three input cells and five output cells instead of the equal default counts. This makes the boundary between input and output cells fall at a non-symmetric point in the eight-bit chain, so a swapped cell order, a wrong capture source or an off-by-one chain length would show up at wso. An unused instruction code is loaded to confirm that it falls back to the bypass bit. Under clamp, core_out is toggled while shift and update pulses arrive, so any leak into the held outputs becomes visible.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_BYPASS  = 3'd0;
  localparam logic [IR_W-1:0] OP_EXTEST  = 3'd1;
  localparam logic [IR_W-1:0] OP_PRELOAD = 3'd2;
  localparam logic [IR_W-1:0] OP_INTEST  = 3'd3;
  localparam logic [IR_W-1:0] OP_CLAMP   = 3'd4;

  typedef struct packed {
    logic chain_sel;   // boundary chain is the serial path
    logic cap_ok;      // capture loads the boundary cells
    logic drv_core;    // core inputs come from update stages
    logic drv_pins;    // chip outputs come from update stages
  } dec_t;

  function automatic dec_t decode(input logic [IR_W-1:0] op);
    dec_t d;
    d = '0;
    case (op)
      OP_EXTEST:  begin d.chain_sel = 1'b1; d.cap_ok = 1'b1; d.drv_pins = 1'b1; end
      OP_PRELOAD: begin d.chain_sel = 1'b1; end
      OP_INTEST:  begin d.chain_sel = 1'b1; d.cap_ok = 1'b1; d.drv_core = 1'b1; end
      OP_CLAMP:   begin d.drv_pins = 1'b1; end
      default:    d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/wrp_instr_reg.sv
module wrp_instr_reg
  import wrp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            si,
  input  logic            sel_i,
  input  logic            shift_i,
  input  logic            update_i,
  output logic            so,
  output logic [IR_W-1:0] op_q
);
  logic [IR_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      op_q <= OP_BYPASS;
    end else begin
      if (sel_i && shift_i) sh_q <= {si, sh_q[IR_W-1:1]};
      if (sel_i && update_i) op_q <= sh_q;
    end
  end

  assign so = sh_q[0];

  assert_ir_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_i && shift_i) |=> (sh_q[IR_W-1] == $past(si)));

  assert_ir_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(sel_i && update_i) |=> $stable(op_q));
endmodule

// File: rtl/wrp_bypass.sv
module wrp_bypass (
  input  logic clk,
  input  logic rst,
  input  logic si,
  input  logic shift_i,
  input  logic capture_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)            q <= 1'b0;
    else if (shift_i)   q <= si;
    else if (capture_i) q <= 1'b0;
  end

  assert_byp_shift_R4: assert property (@(posedge clk) disable iff (rst)
    shift_i |=> (q == $past(si)));

  assert_byp_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (capture_i && !shift_i) |=> !q);
endmodule

// File: rtl/wrp_boundary.sv
module wrp_boundary #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   si,
  input  logic                   shift_i,
  input  logic                   capture_i,
  input  logic                   update_i,
  input  logic [N_IN-1:0]        pin_in,
  input  logic [N_OUT-1:0]       core_out,
  output logic                   so,
  output logic [N_IN+N_OUT-1:0]  upd_q
);
  localparam int NC = N_IN + N_OUT;

  logic [NC:0]   lnk;
  logic [NC-1:0] func;
  logic [NC-1:0] sh_q;

  assign lnk[0] = si;
  assign func   = {core_out, pin_in};

  for (genvar k = 0; k < NC; k++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)            sh_q[k] <= 1'b0;
      else if (shift_i)   sh_q[k] <= lnk[k];
      else if (capture_i) sh_q[k] <= func[k];
    end
    always_ff @(posedge clk) begin
      if (rst)           upd_q[k] <= 1'b0;
      else if (update_i) upd_q[k] <= sh_q[k];
    end
    assign lnk[k+1] = sh_q[k];
  end

  assign so = lnk[NC];

  assert_upd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !update_i |=> $stable(upd_q));
endmodule

// File: rtl/core_test_wrapper.sv
module core_test_wrapper
  import wrp_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             wsi,
  input  logic             shift_en,
  input  logic             capture_en,
  input  logic             update_en,
  input  logic             sel_instr,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  output logic             wso,
  output logic [N_IN-1:0]  core_in,
  output logic [N_OUT-1:0] pin_out
);
  localparam int NC = N_IN + N_OUT;

  logic [IR_W-1:0] op;
  logic            ir_so, byp_so, bnd_so;
  logic [NC-1:0]   bnd_upd;
  dec_t            dec;
  logic            data_sh, data_cap, data_upd;

  assign dec      = decode(op);
  assign data_sh  = shift_en && !sel_instr;
  assign data_cap = capture_en && !shift_en && !sel_instr;
  assign data_upd = update_en && !sel_instr;

  wrp_instr_reg u_ir (
    .clk(wclk), .rst(wrst), .si(wsi), .sel_i(sel_instr),
    .shift_i(shift_en), .update_i(update_en), .so(ir_so), .op_q(op)
  );

  wrp_bypass u_byp (
    .clk(wclk), .rst(wrst), .si(wsi),
    .shift_i(data_sh && !dec.chain_sel),
    .capture_i(data_cap && !dec.chain_sel),
    .q(byp_so)
  );

  wrp_boundary #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bnd (
    .clk(wclk), .rst(wrst), .si(wsi),
    .shift_i(data_sh && dec.chain_sel),
    .capture_i(data_cap && dec.cap_ok),
    .update_i(data_upd && dec.chain_sel),
    .pin_in(pin_in), .core_out(core_out),
    .so(bnd_so), .upd_q(bnd_upd)
  );

  assign core_in = dec.drv_core ? bnd_upd[N_IN-1:0]  : pin_in;
  assign pin_out = dec.drv_pins ? bnd_upd[NC-1:N_IN] : core_out;

  always_ff @(negedge wclk) begin
    if (wrst)           wso <= 1'b0;
    else if (sel_instr) wso <= ir_so;
    else if (dec.chain_sel) wso <= bnd_so;
    else                wso <= byp_so;
  end

  assert_clamp_hold_R11: assert property (@(posedge wclk) disable iff (wrst)
    ((op == OP_CLAMP) && $past(op == OP_CLAMP)) |-> $stable(pin_out));
endmodule

// File: tb/sim_core_test_wrapper.sv
module sim_core_test_wrapper;
  localparam int NI = 3;
  localparam int NO = 5;
  localparam int NT = NI + NO;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, wsi = 1'b0, sh = 1'b0, cap = 1'b0, upd = 1'b0, sel = 1'b0;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] core_out = '0;
  logic wso;
  logic [NI-1:0] core_in;
  logic [NO-1:0] pin_out;

  core_test_wrapper #(.N_IN(NI), .N_OUT(NO)) u0 (
    .wclk(clk), .wrst(rst), .wsi(wsi), .shift_en(sh), .capture_en(cap),
    .update_en(upd), .sel_instr(sel), .pin_in(pin_in), .core_out(core_out),
    .wso(wso), .core_in(core_in), .pin_out(pin_out)
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference state
  bit mch[NT];
  bit mup[NT];
  bit [2:0] mirs, mir;
  bit mbyp;

  function automatic bit on_chain();
    return (mir == 3'd1) || (mir == 3'd2) || (mir == 3'd3);
  endfunction

  task automatic model_edge();
    bit old[NT];
    if (rst) begin
      foreach (mch[i]) begin mch[i] = 0; mup[i] = 0; end
      mirs = 0; mir = 0; mbyp = 0;
    end else if (sel) begin
      if (sh) mirs = {wsi, mirs[2:1]};
      if (upd) mir = mirs;
    end else begin
      foreach (mch[i]) old[i] = mch[i];
      if (sh) begin
        if (on_chain()) begin
          mch[0] = wsi;
          for (int i = 1; i < NT; i++) mch[i] = old[i-1];
        end else mbyp = wsi;
      end else if (cap) begin
        if (mir == 3'd1 || mir == 3'd3) begin
          for (int i = 0; i < NT; i++) mch[i] = (i < NI) ? pin_in[i] : core_out[i-NI];
        end else if (!on_chain()) mbyp = 0;
      end
      if (upd && on_chain()) foreach (mup[i]) mup[i] = old[i];
    end
  endtask

  task automatic check(string t, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", t, got, exp, $time);
    end
  endtask

  task automatic compare();
    bit ew;
    logic [NI-1:0] eci;
    logic [NO-1:0] epo;
    ew = rst ? 1'b0 : sel ? mirs[0] : on_chain() ? mch[NT-1] : mbyp;
    for (int i = 0; i < NI; i++) eci[i] = (mir == 3'd3) ? mup[i] : pin_in[i];
    for (int j = 0; j < NO; j++)
      epo[j] = (mir == 3'd1 || mir == 3'd4) ? mup[NI+j] : core_out[j];
    check({tag, " wso R12"}, {7'd0, wso}, {7'd0, ew});
    check({tag, " core_in"}, 8'(core_in), 8'(eci));
    check({tag, " pin_out"}, 8'(pin_out), 8'(epo));
  endtask

  task automatic cyc(bit w, bit s, bit c, bit u, bit sl);
    wsi = w; sh = s; cap = c; upd = u; sel = sl;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    #1;
    compare();
  endtask

  task automatic load_ir(bit [2:0] code);
    for (int k = 0; k < 3; k++) cyc(code[k], 1, 0, 0, 1);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic shift_data(bit [NT-1:0] pat, int n);
    for (int k = 0; k < n; k++) cyc(pat[k % NT], 1, 0, 0, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    pin_in = 3'b101; core_out = 5'b01101;
    tag = "R1 reset";
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    rst = 1'b0;
    cyc(0, 0, 0, 0, 0);

    tag = "R4 bypass shift";
    shift_data(8'b1011_0110, 8);
    tag = "R4 bypass capture";
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);

    tag = "R2 instr shift";
    for (int k = 0; k < 5; k++) cyc(k[0], 1, 0, 0, 1);
    tag = "R3 update with sel low";
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);

    tag = "R8 R5 preload";
    load_ir(3'd2);
    shift_data(8'b1100_1010, NT);
    cyc(0, 0, 0, 1, 0);
    pin_in = 3'b010; core_out = 5'b10010;
    cyc(0, 0, 0, 0, 0);
    tag = "R6 preload capture ignored";
    cyc(0, 0, 1, 0, 0);
    shift_data(8'b0000_0000, NT);

    tag = "R9 extest";
    load_ir(3'd1);
    shift_data(8'b0110_1101, NT);
    cyc(0, 0, 0, 1, 0);
    core_out = 5'b00111; pin_in = 3'b110;
    cyc(0, 0, 0, 0, 0);
    tag = "R6 extest capture";
    cyc(0, 0, 1, 0, 0);
    tag = "R5 extest shift out";
    shift_data(8'b1111_0000, NT + 2);

    tag = "R10 intest";
    load_ir(3'd3);
    shift_data(8'b1010_0101, NT);
    cyc(0, 0, 0, 1, 0);
    pin_in = 3'b001; core_out = 5'b11000;
    cyc(0, 0, 0, 0, 0);
    tag = "R6 intest capture";
    cyc(0, 0, 1, 0, 0);
    shift_data(8'b0011_1100, NT);
    cyc(0, 0, 0, 1, 0);

    tag = "R11 clamp";
    load_ir(3'd4);
    core_out = 5'b01010;
    tag = "R7 R11 clamp pulses";
    shift_data(8'b1001_0011, 6);
    cyc(0, 0, 0, 1, 0);
    cyc(1, 0, 1, 0, 0);
    core_out = 5'b10101;
    cyc(0, 0, 0, 0, 0);

    tag = "R4 unused code";
    load_ir(3'd6);
    shift_data(8'b0101_1001, 8);
    cyc(0, 0, 0, 1, 0);

    tag = "R1 second reset";
    rst = 1'b1;
    cyc(1, 1, 0, 0, 0);
    rst = 1'b0;
    cyc(0, 0, 0, 0, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule